// File: doc/BRIEF.md
# Floating-Point Butterfly Add/Subtract Unit

This block takes one pair of single-precision (IEEE-754 binary32) operands per cycle and returns both their sum and their difference from that single issue. That is the butterfly step used in FFT and DCT kernels. One result leaves on a primary output and the other on a secondary output. A one-bit opcode chooses which result is primary. Both results are rounded to nearest, ties to even. Subnormal operands are flushed to signed zero, and so are tiny results.

The unit is a two-stage pipeline. The first stage compares magnitudes, aligns the smaller operand and adds or subtracts the significands for both paths. The second stage normalizes, rounds and handles the exponent range. Along with the data the unit reports an exception flag vector, a five-bit class code for the primary result and, when the issue asked for it, a four-bit condition summary.

Top module: `fp_butterfly`

## Requirements
- R1: With in_op = 0, out_primary is A+B and out_secondary is A−B. Both are rounded to nearest, ties to even.
- R2: With in_op = 1 the two results swap: out_primary is A−B and out_secondary is A+B.
- R3: out_valid is asserted exactly two cycles after in_valid. An operation issued on every consecutive cycle returns on every consecutive cycle, in order.
- R4: If either operand is a NaN (exponent all ones, fraction nonzero), both outputs are 0x7FC00000. Flag bit 5 (signaling invalid) is set only when an operand is signaling, which means its fraction MSB is 0.
- R5: Flag bit 6 (infinity minus infinity) is the OR over both paths. Two infinities of equal sign always set it, and the path that subtracts them returns 0x7FC00000.
- R6: A result whose biased exponent reaches 255 after rounding becomes the correctly signed infinity. It sets flag bit 0 (overflow) and bit 2 (inexact).
- R7: A subnormal operand is used as zero of its own sign. A result whose biased exponent falls below 1 becomes zero of its sign and sets flag bit 1 (underflow) and bit 2.
- R8: In out_flags, bit 2 (inexact) is the OR over both paths. Bit 3 is set when the primary fraction was incremented by rounding. Bit 4 is set when the primary result is inexact. Bit 7 is the OR of bits 0, 1, 2, 5 and 6.
- R9: out_class describes the primary result: +normal 00100, −normal 01000, +zero 00010, −zero 10010, +infinity 00101, −infinity 01001, NaN 10001.
- R10: When an operation is issued with in_record = 1, out_cond is loaded from its primary result as it leaves. Bit 3 means negative nonzero, bit 2 positive nonzero, bit 1 zero and bit 0 NaN; infinities count as nonzero. With in_record = 0, out_cond keeps its value.
- R11: While rst is high, the outputs it touches are cleared: out_valid, both results, out_flags, out_class and out_cond.
- R12: An exact zero from operands of opposite sign is +0. A sum of two zeros of the same sign keeps that sign.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair valid this cycle |
| in_op | input | 1 | 0: sum is primary, 1: difference is primary |
| in_record | input | 1 | Update the condition summary from this operation |
| in_a | input | 32 | Operand A, binary32 |
| in_b | input | 32 | Operand B, binary32 |
| out_valid | output | 1 | Results valid |
| out_primary | output | 32 | Result selected by the opcode |
| out_secondary | output | 32 | The other result |
| out_flags | output | 8 | Exception and status flags, layout in R4–R8 |
| out_class | output | 5 | Class code of the primary result |
| out_cond | output | 4 | Condition summary of the last recorded primary result |

## Verification
Each path holds its alignment state in one pipeline register: the larger exponent, the signed significand sum and a special-case override. If that state were wrong, the error would show at the ports two cycles after issue as a wrong result bit, class code or flag. When operations are issued back to back, a stage that held its data, or dropped a valid, would show up as a result belonging to a neighbouring vector. If the record bit were mistimed, out_cond would change on an operation issued without the record bit, or would fail to change on one issued with it. The directed tests are built so that either mistake shows as a wrong value.

// File: rtl/fbf_pkg.sv
`timescale 1ns/1ps
package fbf_pkg;

  // class codes for the primary result
  localparam logic [4:0] CLS_POS_NORM = 5'b00100;
  localparam logic [4:0] CLS_NEG_NORM = 5'b01000;
  localparam logic [4:0] CLS_POS_ZERO = 5'b00010;
  localparam logic [4:0] CLS_NEG_ZERO = 5'b10010;
  localparam logic [4:0] CLS_POS_INF  = 5'b00101;
  localparam logic [4:0] CLS_NEG_INF  = 5'b01001;
  localparam logic [4:0] CLS_QNAN     = 5'b10001;

  // condition summary bits
  localparam logic [3:0] CC_NEG  = 4'b1000;
  localparam logic [3:0] CC_POS  = 4'b0100;
  localparam logic [3:0] CC_ZERO = 4'b0010;
  localparam logic [3:0] CC_NAN  = 4'b0001;

  // flag vector bit positions
  localparam int FLG_OVF  = 0;
  localparam int FLG_UNF  = 1;
  localparam int FLG_INX  = 2;
  localparam int FLG_FR   = 3;
  localparam int FLG_FI   = 4;
  localparam int FLG_SNAN = 5;
  localparam int FLG_ISI  = 6;
  localparam int FLG_SUM  = 7;
  localparam int FLG_W    = 8;

endpackage

// File: rtl/fbf_addpath.sv
`timescale 1ns/1ps
// One signed-add path: stage 1 aligns and adds (registered), stage 2
// normalizes and rounds (combinational, registered by the top).
module fbf_addpath #(
  parameter int EW    = 8,
  parameter int FW    = 23,
  parameter bit NEG_B = 1'b0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic [EW+FW:0] a_i,
  input  logic [EW+FW:0] b_i,
  output logic [EW+FW:0] res_o,
  output logic           ovf_o,
  output logic           unf_o,
  output logic           inx_o,
  output logic           up_o,
  output logic           snan_o,
  output logic           isi_o
);
  localparam int W    = 1 + EW + FW;
  localparam int SW   = FW + 1;          // significand with hidden bit
  localparam int AW   = SW + 3;          // plus guard, round, sticky
  localparam int LW   = SW + AW - 1;     // alignment shifter width
  localparam int EMAX = (1 << EW) - 1;
  localparam int LZW  = $clog2(AW + 1);
  localparam int SHW  = $clog2(AW + 2);
  localparam logic [W-1:0] QNAN = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};
  localparam logic signed [EW+1:0] ONE_S  = 1;
  localparam logic signed [EW+1:0] ZERO_S = 0;
  localparam logic signed [EW+1:0] EMAX_S = EMAX;

  // ---------------- stage 1: classify, order, align, add ----------------
  logic          sa, sb, sx, sy, swap, eff_sub;
  logic [EW-1:0] ea, eb, ex, ey, dexp;
  logic [FW-1:0] fa, fb, fx, fy;
  logic          a_nan, b_nan, a_inf, b_inf, a_snan, b_snan;
  logic [EW+FW-1:0] a_mag, b_mag;
  logic [SHW-1:0] dsh;
  logic [SW-1:0] sigx, sigy;
  logic [LW-1:0] ylong;
  logic [AW-1:0] xal, yal;
  logic [AW:0]   mag;
  logic          spec, spec_snan, spec_isi;
  logic [W-1:0]  spec_val;

  always_comb begin
    sa = a_i[W-1];
    sb = b_i[W-1] ^ NEG_B;
    ea = a_i[W-2:FW];
    eb = b_i[W-2:FW];
    fa = a_i[FW-1:0];
    fb = b_i[FW-1:0];
    a_nan  = (ea == EW'(EMAX)) && (fa != '0);
    b_nan  = (eb == EW'(EMAX)) && (fb != '0);
    a_inf  = (ea == EW'(EMAX)) && (fa == '0);
    b_inf  = (eb == EW'(EMAX)) && (fb == '0);
    a_snan = a_nan && !fa[FW-1];
    b_snan = b_nan && !fb[FW-1];
    // subnormals compare and add as zero
    a_mag = (ea == '0) ? '0 : {ea, fa};
    b_mag = (eb == '0) ? '0 : {eb, fb};
    swap  = b_mag > a_mag;
    sx = swap ? sb : sa;
    sy = swap ? sa : sb;
    ex = swap ? eb : ea;
    ey = swap ? ea : eb;
    fx = swap ? fb : fa;
    fy = swap ? fa : fb;
    sigx = (ex == '0) ? '0 : {1'b1, fx};
    sigy = (ey == '0) ? '0 : {1'b1, fy};
    dexp = ex - ey;
    dsh  = (dexp > EW'(AW + 1)) ? SHW'(AW + 1) : dexp[SHW-1:0];
    ylong = {sigy, {(AW-1){1'b0}}} >> dsh;
    yal   = {ylong[LW-1 -: AW-1], |ylong[LW-AW:0]};
    xal   = {sigx, 3'b000};
    eff_sub = sx ^ sy;
    mag = eff_sub ? ({1'b0, xal} - {1'b0, yal}) : ({1'b0, xal} + {1'b0, yal});

    spec = 1'b1; spec_snan = 1'b0; spec_isi = 1'b0; spec_val = QNAN;
    if (a_nan || b_nan) begin
      spec_snan = a_snan || b_snan;
    end else if (a_inf && b_inf && (sa != sb)) begin
      spec_isi = 1'b1;
    end else if (a_inf) begin
      spec_val = {sa, {EW{1'b1}}, {FW{1'b0}}};
    end else if (b_inf) begin
      spec_val = {sb, {EW{1'b1}}, {FW{1'b0}}};
    end else begin
      spec = 1'b0;
    end
  end

  logic          q_spec, q_snan, q_isi, q_sign;
  logic [W-1:0]  q_spec_val;
  logic [EW-1:0] q_exp;
  logic [AW:0]   q_mag;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_spec <= 1'b0; q_snan <= 1'b0; q_isi <= 1'b0; q_sign <= 1'b0;
      q_spec_val <= '0; q_exp <= '0; q_mag <= '0;
    end else if (en) begin
      q_spec     <= spec;
      q_snan     <= spec_snan;
      q_isi      <= spec_isi;
      q_spec_val <= spec_val;
      q_exp      <= ex;
      q_mag      <= mag;
      // exact cancellation yields +0 under round-to-nearest
      q_sign     <= (eff_sub && (mag == '0)) ? 1'b0 : sx;
    end
  end

  // ---------------- stage 2: normalize and round ----------------
  logic                   carry, g, r, s, lsb, up, inx_raw;
  logic [LZW-1:0]         lz;
  logic [AW-1:0]          m;
  logic [SW:0]            rsig;
  logic signed [EW+1:0]   e_n, e_r;

  always_comb begin
    carry = q_mag[AW];
    lz = LZW'(AW);
    for (int i = 0; i < AW; i++) begin
      if (q_mag[i]) lz = LZW'(AW - 1 - i);
    end
    if (carry) begin
      m   = {q_mag[AW:2], |q_mag[1:0]};
      e_n = $signed({2'b00, q_exp}) + ONE_S;
    end else begin
      m   = q_mag[AW-1:0] << lz;
      e_n = $signed({2'b00, q_exp}) - $signed({{(EW+2-LZW){1'b0}}, lz});
    end
    lsb = m[3]; g = m[2]; r = m[1]; s = m[0];
    inx_raw = g | r | s;
    up   = g & (r | s | lsb);
    rsig = {1'b0, m[AW-1:3]} + {{SW{1'b0}}, up};
    e_r  = e_n + (rsig[SW] ? ONE_S : ZERO_S);

    res_o = '0; ovf_o = 1'b0; unf_o = 1'b0; inx_o = 1'b0;
    up_o = 1'b0; snan_o = 1'b0; isi_o = 1'b0;
    if (q_spec) begin
      res_o  = q_spec_val;
      snan_o = q_snan;
      isi_o  = q_isi;
    end else if (q_mag == '0) begin
      res_o = {q_sign, {(W-1){1'b0}}};
    end else if (e_r >= EMAX_S) begin
      res_o = {q_sign, {EW{1'b1}}, {FW{1'b0}}};
      ovf_o = 1'b1; inx_o = 1'b1;
    end else if (e_r < ONE_S || !(rsig[SW] | rsig[SW-1])) begin
      res_o = {q_sign, {(W-1){1'b0}}};
      unf_o = 1'b1; inx_o = 1'b1;
    end else begin
      res_o = {q_sign, e_r[EW-1:0], rsig[FW-1:0]};
      inx_o = inx_raw;
      up_o  = up;
    end
  end

  // R6
  ovf_gives_inf_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> (res_o[W-2:FW] == EW'(EMAX)) && (res_o[FW-1:0] == '0) && inx_o);

  // R7
  unf_gives_zero_chk: assert property (@(posedge clk) disable iff (rst)
    unf_o |-> (res_o[W-2:0] == '0) && inx_o && !ovf_o);

endmodule

// File: rtl/fbf_classify.sv
`timescale 1ns/1ps
module fbf_classify
  import fbf_pkg::*;
#(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input  logic [EW+FW:0] val_i,
  output logic [4:0]     cls_o,
  output logic [3:0]     cc_o
);
  localparam int W = 1 + EW + FW;

  logic          sgn;
  logic [EW-1:0] e;
  logic [FW-1:0] f;

  always_comb begin
    sgn = val_i[W-1];
    e   = val_i[W-2:FW];
    f   = val_i[FW-1:0];
    if (e == {EW{1'b1}} && f != '0) begin
      cls_o = CLS_QNAN;
      cc_o  = CC_NAN;
    end else if (e == {EW{1'b1}}) begin
      cls_o = sgn ? CLS_NEG_INF : CLS_POS_INF;
      cc_o  = sgn ? CC_NEG : CC_POS;
    end else if (e == '0) begin
      cls_o = sgn ? CLS_NEG_ZERO : CLS_POS_ZERO;
      cc_o  = CC_ZERO;
    end else begin
      cls_o = sgn ? CLS_NEG_NORM : CLS_POS_NORM;
      cc_o  = sgn ? CC_NEG : CC_POS;
    end
  end

endmodule

// File: rtl/fp_butterfly.sv
`timescale 1ns/1ps
module fp_butterfly
  import fbf_pkg::*;
#(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_op,
  input  logic             in_record,
  input  logic [EW+FW:0]   in_a,
  input  logic [EW+FW:0]   in_b,
  output logic             out_valid,
  output logic [EW+FW:0]   out_primary,
  output logic [EW+FW:0]   out_secondary,
  output logic [FLG_W-1:0] out_flags,
  output logic [4:0]       out_class,
  output logic [3:0]       out_cond
);
  localparam int W     = 1 + EW + FW;
  localparam int NPATH = 2;   // path 0: A+B, path 1: A-B
  localparam logic [W-1:0] QNAN = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};

  logic [W-1:0]     pres [NPATH];
  logic [NPATH-1:0] povf, punf, pinx, pup, psnan, pisi;

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    fbf_addpath #(.EW(EW), .FW(FW), .NEG_B(p == 1)) u_path (
      .clk(clk), .rst(rst), .en(in_valid),
      .a_i(in_a), .b_i(in_b),
      .res_o(pres[p]), .ovf_o(povf[p]), .unf_o(punf[p]), .inx_o(pinx[p]),
      .up_o(pup[p]), .snan_o(psnan[p]), .isi_o(pisi[p])
    );
  end

  logic v1, op1, rec1;
  logic [W-1:0]     prim, sec;
  logic [FLG_W-1:0] flg;
  logic [4:0]       cls;
  logic [3:0]       cc;

  always_comb begin
    prim = op1 ? pres[1] : pres[0];
    sec  = op1 ? pres[0] : pres[1];
    flg  = '0;
    flg[FLG_OVF]  = |povf;
    flg[FLG_UNF]  = |punf;
    flg[FLG_INX]  = |pinx;
    flg[FLG_FR]   = op1 ? pup[1]  : pup[0];
    flg[FLG_FI]   = op1 ? pinx[1] : pinx[0];
    flg[FLG_SNAN] = |psnan;
    flg[FLG_ISI]  = |pisi;
    flg[FLG_SUM]  = flg[FLG_OVF] | flg[FLG_UNF] | flg[FLG_INX] |
                    flg[FLG_SNAN] | flg[FLG_ISI];
  end

  fbf_classify #(.EW(EW), .FW(FW)) u_cls (.val_i(prim), .cls_o(cls), .cc_o(cc));

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; op1 <= 1'b0; rec1 <= 1'b0;
      out_valid <= 1'b0; out_primary <= '0; out_secondary <= '0;
      out_flags <= '0; out_class <= '0; out_cond <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        op1  <= in_op;
        rec1 <= in_record;
      end
      out_valid <= v1;
      if (v1) begin
        out_primary   <= prim;
        out_secondary <= sec;
        out_flags     <= flg;
        out_class     <= cls;
      end
      if (v1 && rec1) out_cond <= cc;
    end
  end

  // R3
  latency_two_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (out_valid == $past(in_valid, 2)));

  // R4
  snan_both_nan_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_flags[FLG_SNAN]) |-> (out_primary == QNAN && out_secondary == QNAN));

  // R8
  range_sets_inexact_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (out_flags[FLG_OVF] || out_flags[FLG_UNF])) |->
      (out_flags[FLG_INX] && out_flags[FLG_SUM]));

  // R10
  cond_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !($past(in_valid, 2) && $past(in_record, 2))) |-> $stable(out_cond));

endmodule

// File: tb/test_fp_butterfly.sv
`timescale 1ns/1ps
module test_fp_butterfly;

  typedef struct packed {
    logic        op;
    logic        rec;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] p;
    logic [31:0] s;
    logic [7:0]  flg;
    logic [4:0]  cls;
    logic [3:0]  cnd;
  } vec_t;

  localparam int NV = 15;
  // op rec a b primary secondary flags class cond
  localparam vec_t VT [NV] = '{
    '{1'b0,1'b1,32'h3F800000,32'h3F800000,32'h40000000,32'h00000000,8'h00,5'b00100,4'b0100}, // R1 basic
    '{1'b1,1'b1,32'h3F800000,32'h3F800000,32'h00000000,32'h40000000,8'h00,5'b00010,4'b0010}, // R2 R12 +0
    '{1'b0,1'b1,32'h3F800000,32'h40000000,32'h40400000,32'hBF800000,8'h00,5'b00100,4'b0100}, // R1 negative diff
    '{1'b1,1'b1,32'h3FC00000,32'h3F000000,32'h3F800000,32'h40000000,8'h00,5'b00100,4'b0100}, // R2
    '{1'b0,1'b1,32'h3F800000,32'h33800000,32'h3F800000,32'h3F7FFFFF,8'h94,5'b00100,4'b0100}, // R8 tie to even
    '{1'b0,1'b1,32'h3F800000,32'h33C00000,32'h3F800001,32'h3F7FFFFE,8'h9C,5'b00100,4'b0100}, // R8 round up
    '{1'b0,1'b1,32'h7F7FFFFF,32'h7F7FFFFF,32'h7F800000,32'h00000000,8'h95,5'b00101,4'b0100}, // R6 overflow
    '{1'b0,1'b1,32'h7F800000,32'h7F800000,32'h7F800000,32'h7FC00000,8'hC0,5'b00101,4'b0100}, // R5 inf-inf
    '{1'b0,1'b1,32'h7FC00001,32'h3F800000,32'h7FC00000,32'h7FC00000,8'h00,5'b10001,4'b0001}, // R4 quiet NaN
    '{1'b1,1'b1,32'h7F800001,32'h3F800000,32'h7FC00000,32'h7FC00000,8'hA0,5'b10001,4'b0001}, // R4 signaling NaN
    '{1'b1,1'b1,32'h00800000,32'h00C00000,32'h80000000,32'h01200000,8'h96,5'b10010,4'b0010}, // R7 underflow
    '{1'b0,1'b1,32'h80000000,32'h80000000,32'h80000000,32'h00000000,8'h00,5'b10010,4'b0010}, // R12 -0 + -0
    '{1'b0,1'b0,32'h00000001,32'h3F800000,32'h3F800000,32'hBF800000,8'h00,5'b00100,4'b0010}, // R7 flush, R10 hold
    '{1'b1,1'b1,32'hFF800000,32'h3F800000,32'hFF800000,32'hFF800000,8'h00,5'b01001,4'b1000}, // R9 -inf
    '{1'b0,1'b1,32'hBF800000,32'h00000000,32'hBF800000,32'hBF800000,8'h00,5'b01000,4'b1000}  // R9 -normal
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_op, in_record;
  logic [31:0] in_a, in_b;
  logic        out_valid;
  logic [31:0] out_primary, out_secondary;
  logic [7:0]  out_flags;
  logic [4:0]  out_class;
  logic [3:0]  out_cond;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  fp_butterfly i_fp_butterfly (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_record(in_record),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_primary(out_primary),
    .out_secondary(out_secondary), .out_flags(out_flags), .out_class(out_class),
    .out_cond(out_cond)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string vtag(input int i);
    case (i)
      4, 5:   return "R8";
      6:      return "R6";
      7:      return "R5";
      8, 9:   return "R4";
      10, 12: return "R7";
      11:     return "R12";
      1, 3, 13: return "R2";
      default: return "R1";
    endcase
  endfunction

  task automatic drive(input logic v, input logic op, input logic rec,
                       input logic [31:0] a, input logic [31:0] b);
    in_valid = v; in_op = op; in_record = rec; in_a = a; in_b = b;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL R3 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    drive(1'b0, 1'b0, 1'b0, 32'h0, 32'h0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk("R11", "reset valid",   {31'b0, out_valid}, 32'h0);
    chk("R11", "reset primary", out_primary, 32'h0);
    chk("R11", "reset flags",   {24'b0, out_flags}, 32'h0);
    chk("R11", "reset cond",    {28'b0, out_cond}, 32'h0);
    rst = 1'b0;

    // back-to-back table walk: vector k returns two negedges after it is driven (R3)
    for (int k = 0; k < NV + 2; k++) begin
      @(negedge clk);
      if (k >= 2) begin
        chk("R3", $sformatf("vec%0d valid", k-2), {31'b0, out_valid}, 32'h1);
        chk(vtag(k-2), $sformatf("vec%0d primary", k-2), out_primary, VT[k-2].p);
        chk(vtag(k-2), $sformatf("vec%0d secondary", k-2), out_secondary, VT[k-2].s);
        chk(k-2 == 0 ? "R8" : vtag(k-2), $sformatf("vec%0d flags", k-2),
            {24'b0, out_flags}, {24'b0, VT[k-2].flg});
        chk("R9", $sformatf("vec%0d class", k-2), {27'b0, out_class}, {27'b0, VT[k-2].cls});
        chk("R10", $sformatf("vec%0d cond", k-2), {28'b0, out_cond}, {28'b0, VT[k-2].cnd});
      end
      if (k < NV) drive(1'b1, VT[k].op, VT[k].rec, VT[k].a, VT[k].b);
      else        drive(1'b0, 1'b0, 1'b0, 32'h0, 32'h0);
    end
    @(negedge clk);
    chk("R3", "valid drops after burst", {31'b0, out_valid}, 32'h0);

    // R10: unrecorded positive result leaves cond at -1.0's summary
    drive(1'b1, 1'b0, 1'b0, 32'h3F800000, 32'h3F800000);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 32'h0, 32'h0);
    @(negedge clk);
    chk("R1", "unrecorded primary", out_primary, 32'h40000000);
    chk("R10", "cond held", {28'b0, out_cond}, 32'h8);

    // R10: recorded NaN result loads the NaN bit
    drive(1'b1, 1'b1, 1'b1, 32'h3F800000, 32'hFFC00000);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 32'h0, 32'h0);
    @(negedge clk);
    chk("R10", "cond loaded", {28'b0, out_cond}, 32'h1);
    chk("R4", "nan primary", out_primary, 32'h7FC00000);

    // R5: equal negative infinities under subtract opcode
    drive(1'b1, 1'b1, 1'b1, 32'hFF800000, 32'hFF800000);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 32'h0, 32'h0);
    @(negedge clk);
    chk("R5", "-inf - -inf primary", out_primary, 32'h7FC00000);
    chk("R5", "-inf + -inf secondary", out_secondary, 32'hFF800000);
    chk("R5", "isi flag", {24'b0, out_flags}, 32'hC0);

    // R11: reset in mid-operation clears outputs
    rst = 1'b1;
    @(negedge clk);
    chk("R11", "re-reset valid", {31'b0, out_valid}, 32'h0);
    chk("R11", "re-reset cond", {28'b0, out_cond}, 32'h0);
    chk("R11", "re-reset class", {27'b0, out_class}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    finish_run();
  end

endmodule